// File: doc/BRIEF.md
# Rename-Stage Move Elimination Unit

This block sits in the rename stage and decides, each clock, which incoming register-to-register moves can be resolved by renaming alone instead of being sent to execution. Each rename slot carries one instruction with up to `PAIRS` source/destination register pairs. Every destination has an owning register file index. A slot flagged as a move with a single valid pair is a plain move. A slot with several valid pairs is a swap, and a swap is eliminated whole or not at all.

Each register file has a per-clock budget of eliminations, where a budget of zero means no limit, and a policy bit that limits it to moves whose source is known to hold zero. The unit keeps a known-zero bit and an alias record for every logical register. When a move is eliminated, the destination inherits the source's zero bit and is recorded as an alias of the source's current definition. Any other write clears the destination's alias and sets its zero bit only for a zero idiom. Slots are processed oldest first within one clock. A younger slot sees the budget consumed and the state written by older slots.

Top module: `move_elim_unit`

## Requirements
- R1: After reset no register is known zero and none is aliased. A move into a zero-only file is then refused, and a granted move reports its own source register as the alias.
- R2: `elim_grant[s]` is 1 only when `slot_valid[s]` and `slot_move[s]` are 1, at least one pair is valid, and every valid pair has `pair_elig` set. An invalid slot produces all-zero outputs and changes no state.
- R3: Within one clock the number of granted pairs owned by file f never exceeds `cfg_limit[f]` when that limit is nonzero. Pairs are charged in slot order (slot 0 first), then in pair index order.
- R4: A `cfg_limit[f]` of 0 places no bound on the number of eliminations for file f in a clock.
- R5: When `cfg_zero_only[f]` is 1, a pair owned by file f qualifies only if its source register is known zero.
- R6: For a granted pair, `dst_zero` equals the source's known-zero bit, and that bit is copied into the destination's entry.
- R7: For a granted pair, `alias_reg` is the source's recorded alias target if the source is aliased, and otherwise the source register number. The destination is then recorded as aliased to that value. For any pair that is not granted, `alias_reg` is 0.
- R8: All pairs of a multi-pair slot are judged and read against the state that held before the slot. If any valid pair fails, no pair is eliminated, no budget is consumed and no alias is created.
- R9: For a valid pair of a valid slot that is not granted, the destination's alias is cleared, and its zero bit and `dst_zero` take the value of `slot_zero_idiom`.
- R10: A younger slot in the same clock sees the zero bits, aliases and budget left by older slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_limit | input | N_FILES*LIM_W | Per-file elimination budget per clock, 0 = unlimited |
| cfg_zero_only | input | N_FILES | Per-file zero-source-only policy |
| slot_valid | input | SLOTS | Slot carries an instruction |
| slot_move | input | SLOTS | Instruction is a move or swap candidate |
| slot_zero_idiom | input | SLOTS | Non-eliminated writes of this slot produce zero |
| pair_valid | input | SLOTS*PAIRS | Pair is present |
| pair_src | input | SLOTS*PAIRS*AW | Source logical register |
| pair_dst | input | SLOTS*PAIRS*AW | Destination logical register |
| pair_file | input | SLOTS*PAIRS*FW | Register file that owns the destination |
| pair_elig | input | SLOTS*PAIRS | Destination may be eliminated |
| elim_grant | output | SLOTS | Slot eliminated |
| alias_reg | output | SLOTS*PAIRS*AW | Definition the destination now aliases |
| dst_zero | output | SLOTS*PAIRS | Zero flag carried by the destination |

## Verification
On every cycle the assertions check that grants respect the slot and eligibility gating, that granted pairs per file stay within a nonzero budget and match the internal tally, that zero-only files grant only zero-flagged results, and that refused writes carry the zero-idiom flag and a zero alias. Only the bench scenarios can show the effects that build up over several clocks. These are the zero bit and alias chain carried across instructions, clearing by ordinary writes, the all-or-nothing behaviour of swaps that leaves the budget untouched, unlimited budgets, and the way older slots in the same clock feed younger ones.

// File: rtl/mvel_pkg.sv
package mvel_pkg;

    // A budget of zero means unbounded; otherwise the tally must stay below it.
    function automatic logic within_limit(input int used, input int limit);
        return (limit == 0) || (used < limit);
    endfunction

endpackage

// File: rtl/mvel_slot.sv
module mvel_slot
    import mvel_pkg::*;
#(
    parameter int N_REGS  = 16,
    parameter int N_FILES = 2,
    parameter int PAIRS   = 2,
    parameter int LIM_W   = 3,
    parameter int AW      = 4,
    parameter int FW      = 1,
    parameter int CW      = 3
)(
    input  logic [N_FILES-1:0][LIM_W-1:0] cfg_limit,
    input  logic [N_FILES-1:0]            cfg_zero_only,
    input  logic                          in_valid,
    input  logic                          in_move,
    input  logic                          in_zero_idiom,
    input  logic [PAIRS-1:0]              pv,
    input  logic [PAIRS-1:0][AW-1:0]      src,
    input  logic [PAIRS-1:0][AW-1:0]      dst,
    input  logic [PAIRS-1:0][FW-1:0]      file,
    input  logic [PAIRS-1:0]              elig,
    input  logic [N_FILES-1:0][CW-1:0]    cnt_in,
    input  logic [N_REGS-1:0]             zero_in,
    input  logic [N_REGS-1:0]             av_in,
    input  logic [N_REGS-1:0][AW-1:0]     ar_in,
    output logic                          grant,
    output logic [PAIRS-1:0][AW-1:0]      alias_out,
    output logic [PAIRS-1:0]              dzero_out,
    output logic [N_FILES-1:0][CW-1:0]    cnt_out,
    output logic [N_REGS-1:0]             zero_out,
    output logic [N_REGS-1:0]             av_out,
    output logic [N_REGS-1:0][AW-1:0]     ar_out
);

    logic [N_FILES-1:0][CW-1:0] trial_cnt;

    // Qualify every valid pair against the budget and policy of its file.
    always_comb begin
        logic [N_FILES-1:0][CW-1:0] tally;
        logic ok;
        logic seen;
        tally = cnt_in;
        ok    = 1'b1;
        seen  = 1'b0;
        for (int p = 0; p < PAIRS; p++) begin
            if (pv[p]) begin
                seen = 1'b1;
                if (!elig[p]) ok = 1'b0;
                if (cfg_zero_only[file[p]] && !zero_in[src[p]]) ok = 1'b0;
                if (!within_limit(int'(tally[file[p]]), int'(cfg_limit[file[p]]))) ok = 1'b0;
                tally[file[p]] = tally[file[p]] + CW'(1);
            end
        end
        trial_cnt = tally;
        grant     = in_valid && in_move && seen && ok;
    end

    // Results and map updates; every read uses the pre-slot view (swap semantics).
    always_comb begin
        cnt_out   = grant ? trial_cnt : cnt_in;
        zero_out  = zero_in;
        av_out    = av_in;
        ar_out    = ar_in;
        alias_out = '0;
        dzero_out = '0;
        for (int p = 0; p < PAIRS; p++) begin
            if (in_valid && pv[p]) begin
                if (grant) begin
                    alias_out[p] = av_in[src[p]] ? ar_in[src[p]] : src[p];
                    dzero_out[p] = zero_in[src[p]];
                end else begin
                    dzero_out[p] = in_zero_idiom;
                end
            end
        end
        for (int p = 0; p < PAIRS; p++) begin
            if (in_valid && pv[p]) begin
                zero_out[dst[p]] = dzero_out[p];
                av_out[dst[p]]   = grant;
                ar_out[dst[p]]   = alias_out[p];
            end
        end
    end

endmodule

// File: rtl/mvel_state.sv
module mvel_state #(
    parameter int N_REGS = 16,
    parameter int AW     = 4
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_REGS-1:0]         nxt_zero,
    input  logic [N_REGS-1:0]         nxt_av,
    input  logic [N_REGS-1:0][AW-1:0] nxt_ar,
    output logic [N_REGS-1:0]         cur_zero,
    output logic [N_REGS-1:0]         cur_av,
    output logic [N_REGS-1:0][AW-1:0] cur_ar
);

    typedef struct packed {
        logic [N_REGS-1:0]         zero;
        logic [N_REGS-1:0]         av;
        logic [N_REGS-1:0][AW-1:0] ar;
    } regmap_t;

    regmap_t map_d, map_q;

    always_comb begin
        map_d.zero = nxt_zero;
        map_d.av   = nxt_av;
        map_d.ar   = nxt_ar;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign cur_zero = map_q.zero;
    assign cur_av   = map_q.av;
    assign cur_ar   = map_q.ar;

endmodule

// File: rtl/move_elim_unit.sv
module move_elim_unit #(
    parameter int N_REGS  = 16,
    parameter int N_FILES = 2,
    parameter int SLOTS   = 2,
    parameter int PAIRS   = 2,
    parameter int LIM_W   = 3,
    localparam int AW     = $clog2(N_REGS),
    localparam int FW     = (N_FILES > 1) ? $clog2(N_FILES) : 1
)(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_FILES-1:0][LIM_W-1:0]       cfg_limit,
    input  logic [N_FILES-1:0]                  cfg_zero_only,
    input  logic [SLOTS-1:0]                    slot_valid,
    input  logic [SLOTS-1:0]                    slot_move,
    input  logic [SLOTS-1:0]                    slot_zero_idiom,
    input  logic [SLOTS-1:0][PAIRS-1:0]         pair_valid,
    input  logic [SLOTS-1:0][PAIRS-1:0][AW-1:0] pair_src,
    input  logic [SLOTS-1:0][PAIRS-1:0][AW-1:0] pair_dst,
    input  logic [SLOTS-1:0][PAIRS-1:0][FW-1:0] pair_file,
    input  logic [SLOTS-1:0][PAIRS-1:0]         pair_elig,
    output logic [SLOTS-1:0]                    elim_grant,
    output logic [SLOTS-1:0][PAIRS-1:0][AW-1:0] alias_reg,
    output logic [SLOTS-1:0][PAIRS-1:0]         dst_zero
);

    localparam int CW = $clog2(SLOTS * PAIRS + 1);

    // Stage k holds the view after slots 0..k-1; stage 0 is the registered map.
    logic [N_REGS-1:0]          ch_zero [SLOTS+1];
    logic [N_REGS-1:0]          ch_av   [SLOTS+1];
    logic [N_REGS-1:0][AW-1:0]  ch_ar   [SLOTS+1];
    logic [N_FILES-1:0][CW-1:0] ch_cnt  [SLOTS+1];

    assign ch_cnt[0] = '0;

    mvel_state #(.N_REGS(N_REGS), .AW(AW)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_zero (ch_zero[SLOTS]),
        .nxt_av   (ch_av[SLOTS]),
        .nxt_ar   (ch_ar[SLOTS]),
        .cur_zero (ch_zero[0]),
        .cur_av   (ch_av[0]),
        .cur_ar   (ch_ar[0])
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        mvel_slot #(
            .N_REGS (N_REGS), .N_FILES(N_FILES), .PAIRS(PAIRS),
            .LIM_W  (LIM_W),  .AW(AW), .FW(FW), .CW(CW)
        ) u_slot (
            .cfg_limit     (cfg_limit),
            .cfg_zero_only (cfg_zero_only),
            .in_valid      (slot_valid[s]),
            .in_move       (slot_move[s]),
            .in_zero_idiom (slot_zero_idiom[s]),
            .pv            (pair_valid[s]),
            .src           (pair_src[s]),
            .dst           (pair_dst[s]),
            .file          (pair_file[s]),
            .elig          (pair_elig[s]),
            .cnt_in        (ch_cnt[s]),
            .zero_in       (ch_zero[s]),
            .av_in         (ch_av[s]),
            .ar_in         (ch_ar[s]),
            .grant         (elim_grant[s]),
            .alias_out     (alias_reg[s]),
            .dzero_out     (dst_zero[s]),
            .cnt_out       (ch_cnt[s+1]),
            .zero_out      (ch_zero[s+1]),
            .av_out        (ch_av[s+1]),
            .ar_out        (ch_ar[s+1])
        );
    end

endmodule

// File: rtl/mvel_chk.sv
module mvel_chk #(
    parameter int N_REGS  = 16,
    parameter int N_FILES = 2,
    parameter int SLOTS   = 2,
    parameter int PAIRS   = 2,
    parameter int LIM_W   = 3,
    localparam int AW     = $clog2(N_REGS),
    localparam int FW     = (N_FILES > 1) ? $clog2(N_FILES) : 1,
    localparam int CW     = $clog2(SLOTS * PAIRS + 1)
)(
    input logic                                clk,
    input logic                                rst_n,
    input logic [N_FILES-1:0][LIM_W-1:0]       cfg_limit,
    input logic [N_FILES-1:0]                  cfg_zero_only,
    input logic [SLOTS-1:0]                    slot_valid,
    input logic [SLOTS-1:0]                    slot_move,
    input logic [SLOTS-1:0]                    slot_zero_idiom,
    input logic [SLOTS-1:0][PAIRS-1:0]         pair_valid,
    input logic [SLOTS-1:0][PAIRS-1:0][FW-1:0] pair_file,
    input logic [SLOTS-1:0][PAIRS-1:0]         pair_elig,
    input logic [SLOTS-1:0]                    elim_grant,
    input logic [SLOTS-1:0][PAIRS-1:0][AW-1:0] alias_reg,
    input logic [SLOTS-1:0][PAIRS-1:0]         dst_zero,
    input logic [N_FILES-1:0][CW-1:0]          final_cnt
);

    logic [N_FILES-1:0][CW-1:0] used;

    always_comb begin
        used = '0;
        for (int s = 0; s < SLOTS; s++)
            for (int p = 0; p < PAIRS; p++)
                if (elim_grant[s] && pair_valid[s][p])
                    used[pair_file[s][p]] = used[pair_file[s][p]] + CW'(1);
    end

    for (genvar f = 0; f < N_FILES; f++) begin : g_file
        // R3
        file_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_limit[f] != '0) |-> (int'(used[f]) <= int'(cfg_limit[f])));
        // R3
        tally_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            final_cnt[f] == used[f]);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_s
        // R2
        grant_needs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
            elim_grant[s] |-> (slot_valid[s] && slot_move[s] && (|pair_valid[s])));
        // R2
        grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            elim_grant[s] |-> ((pair_valid[s] & ~pair_elig[s]) == '0));
        for (genvar p = 0; p < PAIRS; p++) begin : g_p
            // R5
            zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (elim_grant[s] && pair_valid[s][p] && cfg_zero_only[pair_file[s][p]])
                |-> dst_zero[s][p]);
            // R9
            plain_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_valid[s] && !elim_grant[s] && pair_valid[s][p])
                |-> (dst_zero[s][p] == slot_zero_idiom[s]));
            // R7
            refused_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !elim_grant[s] |-> (alias_reg[s][p] == '0));
        end
    end

endmodule

bind move_elim_unit mvel_chk #(
    .N_REGS(N_REGS), .N_FILES(N_FILES), .SLOTS(SLOTS), .PAIRS(PAIRS), .LIM_W(LIM_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_limit       (cfg_limit),
    .cfg_zero_only   (cfg_zero_only),
    .slot_valid      (slot_valid),
    .slot_move       (slot_move),
    .slot_zero_idiom (slot_zero_idiom),
    .pair_valid      (pair_valid),
    .pair_file       (pair_file),
    .pair_elig       (pair_elig),
    .elim_grant      (elim_grant),
    .alias_reg       (alias_reg),
    .dst_zero        (dst_zero),
    .final_cnt       (ch_cnt[SLOTS])
);

// File: tb/move_elim_unit_tb_top.sv
`timescale 1ns/1ps
module move_elim_unit_tb_top;

    localparam int S = 2, P = 2, N = 16, F = 2, LW = 3, AW = 4, FW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [F-1:0][LW-1:0]       cfg_limit;
    logic [F-1:0]               cfg_zero_only;
    logic [S-1:0]               slot_valid, slot_move, slot_zero_idiom;
    logic [S-1:0][P-1:0]        pair_valid, pair_elig;
    logic [S-1:0][P-1:0][AW-1:0] pair_src, pair_dst;
    logic [S-1:0][P-1:0][FW-1:0] pair_file;
    logic [S-1:0]               elim_grant;
    logic [S-1:0][P-1:0][AW-1:0] alias_reg;
    logic [S-1:0][P-1:0]        dst_zero;

    move_elim_unit #(.N_REGS(N), .N_FILES(F), .SLOTS(S), .PAIRS(P), .LIM_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .cfg_zero_only(cfg_zero_only),
        .slot_valid(slot_valid), .slot_move(slot_move), .slot_zero_idiom(slot_zero_idiom),
        .pair_valid(pair_valid), .pair_src(pair_src), .pair_dst(pair_dst),
        .pair_file(pair_file), .pair_elig(pair_elig), .elim_grant(elim_grant),
        .alias_reg(alias_reg), .dst_zero(dst_zero)
    );

    typedef struct packed {
        logic [S-1:0]                g;
        logic [S-1:0][P-1:0][AW-1:0] a;
        logic [S-1:0][P-1:0]         z;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Reference map, written from the requirements.
    logic [N-1:0]         m_zero = '0;
    logic [N-1:0]         m_av = '0;
    logic [N-1:0][AW-1:0] m_ar = '0;

    task automatic clr();
        slot_valid = '0; slot_move = '0; slot_zero_idiom = '0;
        pair_valid = '0; pair_elig = '0; pair_src = '0; pair_dst = '0; pair_file = '0;
    endtask

    task automatic slot(int s, bit mv, bit zi);
        slot_valid[s] = 1'b1; slot_move[s] = mv; slot_zero_idiom[s] = zi;
    endtask

    task automatic put(int s, int p, int src, int dst, int file, bit el);
        pair_valid[s][p] = 1'b1; pair_src[s][p] = AW'(src); pair_dst[s][p] = AW'(dst);
        pair_file[s][p] = FW'(file); pair_elig[s][p] = el;
    endtask

    // Driver: predict this cycle's outputs, queue them, advance the model.
    task automatic step(string tag);
        obs_t e;
        int cnt[F];
        int t[F];
        bit ok, any;
        logic [N-1:0] z0, a0;
        logic [N-1:0][AW-1:0] r0;
        e = '0;
        foreach (cnt[f]) cnt[f] = 0;
        for (int s = 0; s < S; s++) begin
            if (slot_valid[s]) begin
                t = cnt; ok = 1; any = 0;
                for (int p = 0; p < P; p++) begin
                    if (pair_valid[s][p]) begin
                        int f;
                        f = int'(pair_file[s][p]);
                        any = 1;
                        if (!pair_elig[s][p]) ok = 0;
                        if (cfg_zero_only[f] && !m_zero[pair_src[s][p]]) ok = 0;
                        if (cfg_limit[f] != 0 && t[f] >= int'(cfg_limit[f])) ok = 0;
                        t[f]++;
                    end
                end
                e.g[s] = slot_move[s] && any && ok;
                z0 = m_zero; a0 = m_av; r0 = m_ar;
                if (e.g[s]) cnt = t;
                for (int p = 0; p < P; p++) begin
                    if (pair_valid[s][p]) begin
                        if (e.g[s]) begin
                            e.a[s][p] = a0[pair_src[s][p]] ? r0[pair_src[s][p]] : pair_src[s][p];
                            e.z[s][p] = z0[pair_src[s][p]];
                            m_av[pair_dst[s][p]] = 1'b1;
                            m_ar[pair_dst[s][p]] = e.a[s][p];
                        end else begin
                            e.z[s][p] = slot_zero_idiom[s];
                            m_av[pair_dst[s][p]] = 1'b0;
                        end
                        m_zero[pair_dst[s][p]] = e.z[s][p];
                    end
                end
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        clr();
    endtask

    // Monitor: compare in the middle of the cycle the item was issued.
    always @(negedge clk) begin : mon
        obs_t e, got;
        string tg;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            got = {elim_grant, alias_reg, dst_zero};
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s actual grant=%b alias=%h zero=%b expected grant=%b alias=%h zero=%b",
                         tg, got.g, got.a, got.z, e.g, e.a, e.z);
            end
        end
    end

    initial begin
        cfg_limit = '0;
        cfg_zero_only = 2'b10;   // file 1 is zero-only
        clr();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        step("R1");                                   // idle after reset
        slot(0, 1, 0); put(0, 0, 5, 6, 1, 1); step("R1"); // no zero known: refused
        slot(0, 1, 0); put(0, 0, 5, 6, 0, 1); step("R1"); // alias = own source 5

        slot(0, 0, 1); put(0, 0, 0, 1, 0, 1); step("R9"); // zero idiom into r1
        slot(0, 1, 0); put(0, 0, 1, 2, 1, 1); step("R5"); // zero-only file accepts
        slot(0, 1, 0); put(0, 0, 2, 3, 1, 1); step("R6"); // zero bit carried to r3

        slot(0, 1, 0); put(0, 0, 3, 4, 0, 1); step("R7");
        slot(0, 1, 0); put(0, 0, 4, 5, 0, 1); step("R7"); // chain resolves to r1

        slot(0, 0, 0); put(0, 0, 0, 4, 0, 1); step("R9"); // ordinary write to r4
        slot(0, 1, 0); put(0, 0, 4, 7, 1, 1); step("R9"); // zero cleared: refused
        slot(0, 1, 0); put(0, 0, 4, 7, 0, 1); step("R9"); // alias cleared: r4

        cfg_limit[0] = 3'd1;
        slot(0, 1, 0); put(0, 0, 8, 9, 0, 1);
        slot(1, 1, 0); put(1, 0, 10, 11, 0, 1); step("R3");
        cfg_limit[0] = 3'd2;
        slot(0, 1, 0); put(0, 0, 8, 9, 0, 1); put(0, 1, 9, 8, 0, 1);
        slot(1, 1, 0); put(1, 0, 10, 11, 0, 1); step("R3");
        cfg_limit[0] = 3'd0;
        slot(0, 1, 0); put(0, 0, 8, 9, 0, 1); put(0, 1, 9, 8, 0, 1);
        slot(1, 1, 0); put(1, 0, 10, 11, 0, 1); put(1, 1, 11, 10, 0, 1); step("R4");

        cfg_limit[0] = 3'd1;
        slot(0, 1, 0); put(0, 0, 1, 2, 0, 1); put(0, 1, 2, 1, 0, 1); step("R8");
        cfg_limit[0] = 3'd2;
        slot(0, 1, 0); put(0, 0, 1, 2, 0, 1); put(0, 1, 2, 1, 0, 1); step("R8");
        slot(0, 1, 0); put(0, 0, 3, 12, 0, 1); put(0, 1, 12, 3, 0, 0);
        slot(1, 1, 0); put(1, 0, 5, 13, 0, 1); put(1, 1, 13, 5, 0, 1); step("R8");

        cfg_limit[0] = 3'd0;
        slot(0, 1, 0); put(0, 0, 6, 14, 0, 0); step("R2");
        slot(0, 0, 0); put(0, 0, 6, 14, 0, 1); step("R2");
        slot_move[0] = 1'b1; put(0, 0, 6, 15, 0, 1); step("R2"); // slot not valid

        slot(0, 0, 1); put(0, 0, 0, 12, 0, 1);
        slot(1, 1, 0); put(1, 0, 12, 13, 1, 1); step("R10");
        slot(0, 1, 0); put(0, 0, 6, 14, 0, 1);
        slot(1, 1, 0); put(1, 0, 14, 15, 0, 1); step("R10");

        for (int i = 0; i < 400; i++) begin
            cfg_limit[0] = LW'($urandom_range(3, 0));
            cfg_limit[1] = LW'($urandom_range(3, 0));
            cfg_zero_only = F'($urandom_range(3, 0));
            for (int s = 0; s < S; s++) begin
                if ($urandom_range(3, 0) != 0) slot(s, $urandom_range(3, 0) != 0, $urandom_range(1, 0) == 1);
                for (int p = 0; p < P; p++)
                    if ($urandom_range(2, 0) != 0)
                        put(s, p, $urandom_range(7, 0), $urandom_range(7, 0),
                            $urandom_range(1, 0), $urandom_range(7, 0) != 0);
            end
            step("R10");
        end

        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule